// File: doc/BRIEF.md
# Two-Object Correlation Trigger Condition

This block forms one physics algorithm bit from four calorimeter candidates of a single type that arrive together for one bunch crossing. It looks for two different candidates, one passing a first energy threshold and position window (leg 1) and another passing a second threshold and window (leg 2). It also checks a missing transverse energy word against its own threshold. The algorithm bit is set only when both the pair condition and the missing-energy condition hold.

All thresholds and window bounds are plain inputs that software loads at run time. They are sampled in the same cycle as the candidates. The result comes out a fixed two cycles after the input strobe, so a downstream decision stage can line up many such bits without any per-algorithm delay matching.

Top module: `corr_cond_top`

## Requirements
- R1: A candidate passes the energy test of a leg when its 6-bit energy (bits [15:10] of its 16-bit slot) is greater than or equal to that leg's energy threshold.
- R2: A candidate passes the position test of a leg when its 5-bit eta (bits [9:5]) lies within lo..hi of that leg's eta bounds, both ends included, and its 5-bit phi (bits [4:0]) lies within lo..hi of that leg's phi bounds, both ends included. Candidate k occupies bits [16k+15:16k] of the 64-bit candidate input.
- R3: The pair condition holds only when some candidate i passes all of leg 1 and a different candidate j (j ≠ i) passes all of leg 2. A single candidate that passes both legs, with no other candidate passing either, does not satisfy it.
- R4: The missing-energy condition holds when the missing-energy word is greater than or equal to its threshold.
- R5: The algorithm bit is the AND of the pair condition and the missing-energy condition.
- R6: The output valid rises exactly two clock cycles after an input valid, and the algorithm bit is 0 in any cycle where the output valid is 0.
- R7: While reset (active low, synchronous) is asserted, the output valid and the algorithm bit are 0.
- R8: Thresholds and windows are taken in the same cycle as the candidates. Changing them after that cycle does not alter the result for those candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Candidates and missing energy are valid this cycle |
| cands | input | 64 | Four packed 16-bit candidates |
| met | input | 10 | Missing transverse energy word |
| l1_e_thr | input | 6 | Leg 1 energy threshold |
| l1_eta_lo | input | 5 | Leg 1 eta lower bound |
| l1_eta_hi | input | 5 | Leg 1 eta upper bound |
| l1_phi_lo | input | 5 | Leg 1 phi lower bound |
| l1_phi_hi | input | 5 | Leg 1 phi upper bound |
| l2_e_thr | input | 6 | Leg 2 energy threshold |
| l2_eta_lo | input | 5 | Leg 2 eta lower bound |
| l2_eta_hi | input | 5 | Leg 2 eta upper bound |
| l2_phi_lo | input | 5 | Leg 2 phi lower bound |
| l2_phi_hi | input | 5 | Leg 2 phi upper bound |
| met_thr | input | 10 | Missing-energy threshold |
| algo_valid | output | 1 | Algorithm bit is valid |
| algo_bit | output | 1 | Algorithm result |

## Verification
A wrong leg-match register or an unmasked diagonal pair shows up at the algorithm bit for that crossing, exactly two cycles after the strobe. The sweep makes each failing combination visible at once. A valid bit stuck or skipped in the pipeline shows as a missing or extra output strobe on the very next check. A missing-energy flag taken from the wrong stage shows as a bit that disagrees with its threshold on the crossing where the missing energy sits right at the limit.

// File: rtl/corr_cond_pkg.sv
package corr_cond_pkg;
    parameter int N_OBJ = 4;
    parameter int E_W   = 6;
    parameter int ETA_W = 5;
    parameter int PHI_W = 5;
    parameter int MET_W = 10;
    localparam int OBJ_W  = E_W + ETA_W + PHI_W;
    localparam int BUS_W  = OBJ_W * N_OBJ;

    typedef struct packed {
        logic [E_W-1:0]   e;
        logic [ETA_W-1:0] eta;
        logic [PHI_W-1:0] phi;
    } obj_t;

    typedef struct packed {
        logic [E_W-1:0]   e_thr;
        logic [ETA_W-1:0] eta_lo;
        logic [ETA_W-1:0] eta_hi;
        logic [PHI_W-1:0] phi_lo;
        logic [PHI_W-1:0] phi_hi;
    } leg_cfg_t;

    typedef struct packed {
        logic             s1_vld;
        logic [N_OBJ-1:0] s1_leg1;
        logic [N_OBJ-1:0] s1_leg2;
        logic             s1_met;
        logic             out_vld;
        logic             out_bit;
    } pipe_t;
endpackage

// File: rtl/obj_leg_match.sv
module obj_leg_match
    import corr_cond_pkg::*;
(
    input  obj_t     obj,
    input  leg_cfg_t cfg,
    output logic     pass
);
    logic e_ok, eta_ok, phi_ok;

    always_comb begin
        e_ok   = (obj.e >= cfg.e_thr);
        eta_ok = (obj.eta >= cfg.eta_lo) && (obj.eta <= cfg.eta_hi);
        phi_ok = (obj.phi >= cfg.phi_lo) && (obj.phi <= cfg.phi_hi);
        pass   = e_ok && eta_ok && phi_ok;
    end
endmodule

// File: rtl/pair_combiner.sv
module pair_combiner #(
    parameter int N = 4
) (
    input  logic [N-1:0] leg_a,
    input  logic [N-1:0] leg_b,
    output logic         hit
);
    logic [N*N-1:0] pair_ok;

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (i == j) begin : g_diag
                assign pair_ok[i*N+j] = 1'b0;
            end else begin : g_off
                assign pair_ok[i*N+j] = leg_a[i] & leg_b[j];
            end
        end
    end

    assign hit = |pair_ok;
endmodule

// File: rtl/corr_cond_top.sv
module corr_cond_top
    import corr_cond_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] cands,
    input  logic [MET_W-1:0] met,
    input  logic [E_W-1:0]   l1_e_thr,
    input  logic [ETA_W-1:0] l1_eta_lo,
    input  logic [ETA_W-1:0] l1_eta_hi,
    input  logic [PHI_W-1:0] l1_phi_lo,
    input  logic [PHI_W-1:0] l1_phi_hi,
    input  logic [E_W-1:0]   l2_e_thr,
    input  logic [ETA_W-1:0] l2_eta_lo,
    input  logic [ETA_W-1:0] l2_eta_hi,
    input  logic [PHI_W-1:0] l2_phi_lo,
    input  logic [PHI_W-1:0] l2_phi_hi,
    input  logic [MET_W-1:0] met_thr,
    output logic             algo_valid,
    output logic             algo_bit
);
    leg_cfg_t         cfg1, cfg2;
    logic [N_OBJ-1:0] m1, m2;
    logic             pair_hit;
    pipe_t            p_d, p_q;

    assign cfg1 = '{e_thr: l1_e_thr, eta_lo: l1_eta_lo, eta_hi: l1_eta_hi,
                    phi_lo: l1_phi_lo, phi_hi: l1_phi_hi};
    assign cfg2 = '{e_thr: l2_e_thr, eta_lo: l2_eta_lo, eta_hi: l2_eta_hi,
                    phi_lo: l2_phi_lo, phi_hi: l2_phi_hi};

    for (genvar k = 0; k < N_OBJ; k++) begin : g_obj
        obj_t o;
        assign o = cands[k*OBJ_W +: OBJ_W];
        obj_leg_match u_m1 (.obj(o), .cfg(cfg1), .pass(m1[k]));
        obj_leg_match u_m2 (.obj(o), .cfg(cfg2), .pass(m2[k]));
    end

    pair_combiner #(.N(N_OBJ)) u_pair (
        .leg_a (p_q.s1_leg1),
        .leg_b (p_q.s1_leg2),
        .hit   (pair_hit)
    );

    always_comb begin
        p_d         = p_q;
        p_d.s1_vld  = in_valid;
        p_d.s1_leg1 = in_valid ? m1 : '0;
        p_d.s1_leg2 = in_valid ? m2 : '0;
        p_d.s1_met  = in_valid && (met >= met_thr);
        p_d.out_vld = p_q.s1_vld;
        p_d.out_bit = p_q.s1_vld && p_q.s1_met && pair_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign algo_valid = p_q.out_vld;
    assign algo_bit   = p_q.out_bit;

    // cycles since reset release, saturating, used to keep $past inside history
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)         age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    a_r6_bit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !algo_valid |-> !algo_bit);

    a_r6_two_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (algo_valid == $past(in_valid, 2)));

    a_r5_bit_needs_met: assert property (@(posedge clk) disable iff (!rst_n)
        algo_bit |-> $past(p_q.s1_met));

    a_r5_and_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (p_q.s1_vld && p_q.s1_met && pair_hit) |=> algo_bit);

    a_r3_distinct_pair: assert property (@(posedge clk) disable iff (!rst_n)
        pair_hit |-> ($countones(p_q.s1_leg1 | p_q.s1_leg2) >= 2
                      && p_q.s1_leg1 != '0 && p_q.s1_leg2 != '0));

    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!algo_valid && !algo_bit));
endmodule

// File: tb/corr_cond_top_bench.sv
module corr_cond_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] cands = '0;
    logic [9:0]  met = '0, met_thr = '0;
    logic [5:0]  l1_e_thr = '0, l2_e_thr = '0;
    logic [4:0]  l1_eta_lo = '0, l1_eta_hi = '0, l1_phi_lo = '0, l1_phi_hi = '0;
    logic [4:0]  l2_eta_lo = '0, l2_eta_hi = '0, l2_phi_lo = '0, l2_phi_hi = '0;
    logic        algo_valid, algo_bit;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    corr_cond_top u_corr_cond_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cands(cands), .met(met),
        .l1_e_thr(l1_e_thr), .l1_eta_lo(l1_eta_lo), .l1_eta_hi(l1_eta_hi),
        .l1_phi_lo(l1_phi_lo), .l1_phi_hi(l1_phi_hi),
        .l2_e_thr(l2_e_thr), .l2_eta_lo(l2_eta_lo), .l2_eta_hi(l2_eta_hi),
        .l2_phi_lo(l2_phi_lo), .l2_phi_hi(l2_phi_hi),
        .met_thr(met_thr), .algo_valid(algo_valid), .algo_bit(algo_bit)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual cycles=%0d expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] mk(input int e, input int eta, input int phi);
        return {e[5:0], eta[4:0], phi[4:0]};
    endfunction

    function automatic bit leg_ok(input logic [15:0] o, input int thr,
                                  input int elo, input int ehi, input int plo, input int phi_hi);
        int e, eta, phi;
        e = o[15:10]; eta = o[9:5]; phi = o[4:0];
        return (e >= thr) && (eta >= elo) && (eta <= ehi) && (phi >= plo) && (phi <= phi_hi);
    endfunction

    function automatic bit ref_bit(input logic [63:0] c, input int m, input int mt);
        bit a, b, pair;
        pair = 0;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                a = leg_ok(c[i*16 +: 16], l1_e_thr, l1_eta_lo, l1_eta_hi, l1_phi_lo, l1_phi_hi);
                b = leg_ok(c[j*16 +: 16], l2_e_thr, l2_eta_lo, l2_eta_hi, l2_phi_lo, l2_phi_hi);
                if (i != j && a && b) pair = 1;
            end
        return pair && (m >= mt);
    endfunction

    task automatic check(input string tag, input logic v, input logic b,
                         input logic ev, input logic eb);
        checks++;
        if (v !== ev || b !== eb) begin
            errors++;
            $display("FAIL %s: actual valid=%0b bit=%0b expected valid=%0b bit=%0b",
                     tag, v, b, ev, eb);
        end
    endtask

    // drive one crossing at a negedge, read result two edges later
    task automatic run_one(input string tag, input logic v, input logic [63:0] c,
                           input int m, input logic expb, input bit spoil);
        in_valid = v; cands = c; met = m[9:0];
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (spoil) begin
            l1_e_thr = 6'd63; l2_e_thr = 6'd63; met_thr = 10'd1023;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, algo_valid, algo_bit, v, v & expb);
    endtask

    task automatic std_cfg;
        l1_e_thr = 6'd20; l1_eta_lo = 5'd4;  l1_eta_hi = 5'd12; l1_phi_lo = 5'd0; l1_phi_hi = 5'd31;
        l2_e_thr = 6'd40; l2_eta_lo = 5'd12; l2_eta_hi = 5'd20; l2_phi_lo = 5'd3; l2_phi_hi = 5'd8;
        met_thr  = 10'd100;
    endtask

    function automatic logic [15:0] pick(input int c);
        case (c)
            0: return mk(19, 5, 1);
            1: return mk(20, 4, 0);
            2: return mk(40, 12, 5);
            3: return mk(40, 13, 3);
            4: return mk(39, 20, 8);
            5: return mk(63, 20, 9);
            6: return mk(50, 3, 4);
            default: return mk(41, 21, 7);
        endcase
    endfunction

    initial begin
        logic [63:0] c;
        std_cfg();
        in_valid = 1'b1;
        cands = {4{mk(63, 12, 5)}};
        met = 10'd500;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 reset holds outputs low", algo_valid, algo_bit, 1'b0, 1'b0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R7 idle after reset", algo_valid, algo_bit, 1'b0, 1'b0);

        // R3: one candidate passing both legs alone must not fire
        c = {mk(0, 0, 0), mk(0, 0, 0), mk(0, 0, 0), mk(40, 12, 5)};
        run_one("R3 same candidate on both legs", 1'b1, c, 200, 1'b0, 0);
        c = {mk(0, 0, 0), mk(40, 12, 5), mk(0, 0, 0), mk(40, 12, 5)};
        run_one("R3 two distinct both-leg candidates", 1'b1, c, 200, 1'b1, 0);
        // R1 boundary: energies exactly at thresholds
        c = {mk(40, 13, 3), mk(0, 0, 0), mk(20, 4, 0), mk(0, 0, 0)};
        run_one("R1 energy equal to threshold passes", 1'b1, c, 100, 1'b1, 0);
        c = {mk(39, 13, 3), mk(0, 0, 0), mk(20, 4, 0), mk(0, 0, 0)};
        run_one("R1 energy one below leg2 threshold", 1'b1, c, 100, 1'b0, 0);
        // R2 upper window edges inclusive, one past fails
        c = {mk(63, 20, 8), mk(63, 12, 31), mk(0, 0, 0), mk(0, 0, 0)};
        run_one("R2 inclusive upper edges", 1'b1, c, 100, 1'b1, 0);
        c = {mk(63, 20, 9), mk(63, 12, 31), mk(0, 0, 0), mk(0, 0, 0)};
        run_one("R2 phi one above leg2 window", 1'b1, c, 100, 1'b0, 0);
        // R4 boundary
        c = {mk(40, 13, 3), mk(20, 4, 0), mk(0, 0, 0), mk(0, 0, 0)};
        run_one("R4 missing energy one below threshold", 1'b1, c, 99, 1'b0, 0);
        run_one("R5 both conditions true", 1'b1, c, 100, 1'b1, 0);
        // R6 invalid input gives no strobe
        run_one("R6 no strobe without input valid", 1'b0, c, 100, 1'b0, 0);
        // R8 config changed after capture cycle
        run_one("R8 config sampled with candidates", 1'b1, c, 100, 1'b1, 1);
        std_cfg();
        // R6 back-to-back crossings keep their own results
        @(negedge clk);
        in_valid = 1'b1; cands = c; met = 10'd100;
        @(negedge clk);
        met = 10'd0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 first of back-to-back", algo_valid, algo_bit, 1'b1, 1'b1);
        @(negedge clk);
        check("R6 second of back-to-back", algo_valid, algo_bit, 1'b1, 1'b0);
        @(negedge clk);
        check("R6 strobe drops after burst", algo_valid, algo_bit, 1'b0, 1'b0);

        // near-exhaustive sweep: 8 candidate kinds in each of 4 slots
        for (int p = 0; p < 4096; p++) begin
            int m;
            logic v;
            c = {pick((p >> 9) & 7), pick((p >> 6) & 7), pick((p >> 3) & 7), pick(p & 7)};
            m = ((p % 3) == 0) ? 99 : 100;
            v = ((p % 7) != 6);
            run_one("R1/R2/R3/R4/R5/R6 sweep", v, c, m, ref_bit(c, m, 100), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule